// File: doc/BRIEF.md
# Serial EEPROM Word Reader

This block fetches one 16-bit word from a small serial EEPROM that uses a four-wire interface: select, serial clock, a line toward the memory and a line back from it. A client raises a request with a word address. The reader keeps select low for a minimum guard time, then raises it and sends a start bit and a two-bit read opcode (together the pattern 1,1,0). It then sends the word address most significant bit first and clocks sixteen data bits back, also most significant bit first. Finally it drops select and presents the word with a one-cycle completion pulse.

All serial timing comes from the system clock. One parameter gives the number of system clock cycles per microsecond. Two more give the minimum select-low time and the minimum serial clock period in microseconds. The reader turns these into cycle counts. A request that arrives while an access is running is dropped.

Top module: `serial_rom_reader`

## Requirements
- R1: During and straight after reset, select, serial clock, the line toward the memory and the completion pulse are all low, and the returned word is zero.
- R2: Before every rise of select, select has been low for at least CLK_PER_US*CS_LOW_US consecutive cycles. The serial clock is low when select rises.
- R3: The first three bits sent in an access are 1, 1, 0 in that order: a start bit of 1, then the read opcode 1,0.
- R4: Directly after those three bits, the ADDR_W-bit word address is sent most significant bit first.
- R5: While select is high, every low phase and every high phase of the serial clock lasts exactly ceil(CLK_PER_US*SK_PERIOD_US/2) cycles. The serial clock is never high while select is low.
- R6: The line toward the memory changes only while the serial clock is low. It holds its value for the whole of each high phase.
- R7: After the address, DATA_W bits are taken from the memory line on the rising serial clock edges, most significant bit first, and become the returned word. The line toward the memory is 0 during these bits.
- R8: Each access has exactly 3+ADDR_W+DATA_W rising serial clock edges. Select is then low and the completion pulse is high for exactly one cycle.
- R9: A request that arrives while an access is in progress is ignored. It neither restarts the transfer nor starts a second access after the first one ends.
- R10: The returned word changes only in the cycle of the completion pulse. It holds that value until the next completion.

Top module ports are listed below in port-list order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| req_i | input | 1 | Start a read; sampled only when idle |
| addr_i | input | ADDR_W | Word address, captured with the request |
| done_o | output | 1 | One-cycle completion pulse |
| data_o | output | DATA_W | Last word read |
| rom_cs_o | output | 1 | Memory select, active high |
| rom_sk_o | output | 1 | Serial clock to the memory |
| rom_mosi_o | output | 1 | Serial data toward the memory |
| rom_miso_i | input | 1 | Serial data from the memory |

## Verification
The bench models the memory. It reads every address of a 6-bit configuration and returns an arithmetic function of the address. A reader that dropped or duplicated a serial edge would shift the captured word or the decoded address, and an off-by-one in the bit counter would show up as a wrong edge count at completion. Phase widths are measured cycle by cycle. A timer loaded with N instead of N-1 would stretch every phase by one cycle, and a missing guard state would raise select too early. Requests are injected in mid-transfer and held high across back-to-back reads. A reader that accepted them would restart the sequence, send a foreign address or produce an extra completion.

// File: rtl/srr_pkg.sv
package srr_pkg;
    typedef enum logic [2:0] {
        SRR_IDLE,
        SRR_CSLOW,
        SRR_SKLO,
        SRR_SKHI,
        SRR_DONE
    } srr_state_e;

    localparam int          SRR_PFX_W    = 3;
    localparam logic [2:0]  SRR_READ_PFX = 3'b110;
endpackage

// File: rtl/srr_timer.sv
module srr_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             load_i,
    input  logic [CNT_W-1:0] val_i,
    output logic             expired_o
);
    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load_i) begin
            cnt_d = val_i;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign expired_o = (cnt_q == '0);
endmodule

// File: rtl/srr_shreg.sv
module srr_shreg #(
    parameter int W = 8
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic         load_i,
    input  logic [W-1:0] load_val_i,
    input  logic         shift_i,
    input  logic         ser_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] sh_d, sh_q;

    always_comb begin
        sh_d = sh_q;
        if (load_i) begin
            sh_d = load_val_i;
        end else if (shift_i) begin
            sh_d = {sh_q[W-2:0], ser_i};
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            sh_q <= '0;
        end else begin
            sh_q <= sh_d;
        end
    end

    assign q_o = sh_q;
endmodule

// File: rtl/serial_rom_reader.sv
module serial_rom_reader
    import srr_pkg::*;
#(
    parameter int CLK_PER_US   = 200,
    parameter int CS_LOW_US    = 1,
    parameter int SK_PERIOD_US = 4,
    parameter int ADDR_W       = 6,
    parameter int DATA_W       = 16
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              req_i,
    input  logic [ADDR_W-1:0] addr_i,
    output logic              done_o,
    output logic [DATA_W-1:0] data_o,
    output logic              rom_cs_o,
    output logic              rom_sk_o,
    output logic              rom_mosi_o,
    input  logic              rom_miso_i
);
    localparam int HALF_CYC  = (CLK_PER_US * SK_PERIOD_US + 1) / 2;
    localparam int CSLOW_CYC = CLK_PER_US * CS_LOW_US;
    localparam int TMR_MAX   = (HALF_CYC > CSLOW_CYC) ? HALF_CYC : CSLOW_CYC;
    localparam int TMR_W     = $clog2(TMR_MAX + 1);
    localparam int CMD_W     = SRR_PFX_W + ADDR_W;
    localparam int NBITS     = CMD_W + DATA_W;
    localparam int BIT_W     = $clog2(NBITS + 1);

    typedef struct packed {
        srr_state_e        state;
        logic [BIT_W-1:0]  bit_idx;
        logic [DATA_W-1:0] word;
    } ctl_t;

    ctl_t c_d, c_q;

    logic             tmr_load;
    logic [TMR_W-1:0] tmr_val;
    logic             tmr_exp;
    logic             tx_load, tx_shift;
    logic             rx_load, rx_shift;
    logic [NBITS-1:0] tx_vec;
    logic [DATA_W-1:0] rx_vec;

    srr_timer #(.CNT_W(TMR_W)) tmr_i (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .load_i    (tmr_load),
        .val_i     (tmr_val),
        .expired_o (tmr_exp)
    );

    srr_shreg #(.W(NBITS)) tx_i (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .load_i     (tx_load),
        .load_val_i ({SRR_READ_PFX, addr_i, {DATA_W{1'b0}}}),
        .shift_i    (tx_shift),
        .ser_i      (1'b0),
        .q_o        (tx_vec)
    );

    srr_shreg #(.W(DATA_W)) rx_i (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .load_i     (rx_load),
        .load_val_i ({DATA_W{1'b0}}),
        .shift_i    (rx_shift),
        .ser_i      (rom_miso_i),
        .q_o        (rx_vec)
    );

    always_comb begin
        c_d      = c_q;
        tmr_load = 1'b0;
        tmr_val  = '0;
        tx_load  = 1'b0;
        tx_shift = 1'b0;
        rx_load  = 1'b0;
        rx_shift = 1'b0;
        case (c_q.state)
            SRR_IDLE: begin
                if (req_i) begin
                    c_d.state   = SRR_CSLOW;
                    c_d.bit_idx = '0;
                    tmr_load    = 1'b1;
                    tmr_val     = TMR_W'(CSLOW_CYC - 1);
                    tx_load     = 1'b1;
                    rx_load     = 1'b1;
                end
            end
            SRR_CSLOW: begin
                if (tmr_exp) begin
                    c_d.state = SRR_SKLO;
                    tmr_load  = 1'b1;
                    tmr_val   = TMR_W'(HALF_CYC - 1);
                end
            end
            SRR_SKLO: begin
                if (tmr_exp) begin
                    c_d.state = SRR_SKHI;
                    tmr_load  = 1'b1;
                    tmr_val   = TMR_W'(HALF_CYC - 1);
                    rx_shift  = (c_q.bit_idx >= BIT_W'(CMD_W));
                end
            end
            SRR_SKHI: begin
                if (tmr_exp) begin
                    if (c_q.bit_idx == BIT_W'(NBITS - 1)) begin
                        c_d.state = SRR_DONE;
                        c_d.word  = rx_vec;
                    end else begin
                        c_d.state   = SRR_SKLO;
                        c_d.bit_idx = c_q.bit_idx + 1'b1;
                        tmr_load    = 1'b1;
                        tmr_val     = TMR_W'(HALF_CYC - 1);
                        tx_shift    = 1'b1;
                    end
                end
            end
            SRR_DONE: c_d.state = SRR_IDLE;
            default:  c_d.state = SRR_IDLE;
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            c_q <= '{state: SRR_IDLE, bit_idx: '0, word: '0};
        end else begin
            c_q <= c_d;
        end
    end

    assign rom_cs_o   = (c_q.state == SRR_SKLO) || (c_q.state == SRR_SKHI);
    assign rom_sk_o   = (c_q.state == SRR_SKHI);
    assign rom_mosi_o = rom_cs_o & tx_vec[NBITS-1];
    assign done_o     = (c_q.state == SRR_DONE);
    assign data_o     = c_q.word;

    AST_CS_RISE_GUARDED: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(rom_cs_o) |-> (!rom_sk_o && $past(c_q.state) == SRR_CSLOW)) else $error("cs rise"); // R2
    AST_SK_INSIDE_CS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rom_sk_o |-> rom_cs_o) else $error("sk without cs"); // R5
    AST_MOSI_HOLD_SKHI: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rom_sk_o && $past(rom_sk_o)) |-> $stable(rom_mosi_o)) else $error("mosi moved"); // R6
    AST_TX_TAIL_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rom_cs_o && c_q.bit_idx >= BIT_W'(CMD_W)) |-> (tx_vec == '0)) else $error("tail"); // R7
    AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |=> !done_o) else $error("done width"); // R8
    AST_DONE_AFTER_SK: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |-> (!rom_cs_o && $past(rom_sk_o))) else $error("done place"); // R8
    AST_NO_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rom_cs_o |=> (c_q.state != SRR_CSLOW)) else $error("restart"); // R9
    AST_WORD_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !$stable(data_o) |-> done_o) else $error("word moved"); // R10
endmodule

// File: tb/serial_rom_reader_tb.sv
`timescale 1ns/1ps
module serial_rom_reader_tb_top;
    localparam int CLK_PER_US   = 2;
    localparam int CS_LOW_US    = 1;
    localparam int SK_PERIOD_US = 4;
    localparam int ADDR_W       = 6;
    localparam int DATA_W       = 16;
    localparam int HALF         = (CLK_PER_US * SK_PERIOD_US + 1) / 2;
    localparam int CSLOW        = CLK_PER_US * CS_LOW_US;
    localparam int CMD_W        = 3 + ADDR_W;
    localparam int NBITS        = CMD_W + DATA_W;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req = 1'b0;
    logic [ADDR_W-1:0] addr = '0;
    logic done, cs, sk, mosi;
    logic miso = 1'b0;
    logic [DATA_W-1:0] dout;

    int checks = 0;
    int fails  = 0;
    int done_cnt = 0;
    int ph_cnt = 0;
    int cslow_cnt = 0;
    int rcnt = 0;
    logic cs_prev = 1'b0, sk_prev = 1'b0, done_prev = 1'b0, hi_mosi = 1'b0;
    logic [NBITS-1:0] rx_all = '0;
    logic [ADDR_W-1:0] cur_addr = '0;

    always #2.5 clk = ~clk;

    serial_rom_reader #(
        .CLK_PER_US(CLK_PER_US), .CS_LOW_US(CS_LOW_US), .SK_PERIOD_US(SK_PERIOD_US),
        .ADDR_W(ADDR_W), .DATA_W(DATA_W)
    ) dut_i (
        .clk_i(clk), .rst_ni(rst_n), .req_i(req), .addr_i(addr),
        .done_o(done), .data_o(dout), .rom_cs_o(cs), .rom_sk_o(sk),
        .rom_mosi_o(mosi), .rom_miso_i(miso)
    );

    function automatic logic [DATA_W-1:0] exp_word(input logic [ADDR_W-1:0] a);
        logic [31:0] m;
        m = 32'(a) * 32'd40503;
        return DATA_W'(m) ^ 16'h5AA5;
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // memory model and protocol monitor
    always @(negedge clk) begin
        if (rst_n) begin
            if (done) begin
                chk(!done_prev, "R8 done lasts one cycle", 32'(done_prev), 0);
                chk(!cs, "R8 select low at done", 32'(cs), 0);
                chk(rcnt == NBITS, "R8 rising edge count", rcnt, NBITS);
                chk(rx_all[NBITS-1 -: 3] == 3'b110, "R3 read prefix", 32'(rx_all[NBITS-1 -: 3]), 32'b110);
                chk(rx_all[NBITS-4 -: ADDR_W] == cur_addr, "R4 address bits",
                    32'(rx_all[NBITS-4 -: ADDR_W]), 32'(cur_addr));
                chk(rx_all[DATA_W-1:0] == '0, "R7 mosi low in data phase", 32'(rx_all[DATA_W-1:0]), 0);
                chk(dout == exp_word(cur_addr), "R7 returned word", 32'(dout), 32'(exp_word(cur_addr)));
                done_cnt++;
            end
            done_prev = done;
            if (sk && !cs) chk(1'b0, "R5 clock outside select", 32'(sk), 0);
            if (cs && !cs_prev) begin
                chk(cslow_cnt >= CSLOW, "R2 select low guard", cslow_cnt, CSLOW);
                chk(!sk, "R2 clock low at select rise", 32'(sk), 0);
                rcnt = 0;
                rx_all = '0;
            end
            if (cs) cslow_cnt = 0; else cslow_cnt++;
            if (cs) begin
                if (cs_prev && sk == sk_prev) ph_cnt++;
                else begin
                    if (cs_prev) chk(ph_cnt == HALF, "R5 clock phase width", ph_cnt, HALF);
                    ph_cnt = 1;
                end
            end else if (cs_prev) begin
                chk(ph_cnt == HALF, "R5 last phase width", ph_cnt, HALF);
            end
            if (cs && sk && !sk_prev) begin
                rx_all = {rx_all[NBITS-2:0], mosi};
                rcnt++;
                hi_mosi = mosi;
            end else if (cs && sk && sk_prev) begin
                if (mosi != hi_mosi) chk(1'b0, "R6 mosi moved while clock high", 32'(mosi), 32'(hi_mosi));
            end
            if (cs && !sk && sk_prev && rcnt >= CMD_W)
                miso = exp_word(cur_addr)[DATA_W-1-(rcnt-CMD_W)];
            cs_prev = cs;
            sk_prev = sk;
        end
    end

    task automatic read_word(input logic [ADDR_W-1:0] a, input bit poke);
        int n;
        n = done_cnt;
        @(negedge clk);
        req = 1'b1; addr = a; cur_addr = a;
        @(negedge clk);
        req = 1'b0; addr = ~a;
        if (poke) begin
            repeat (30) @(negedge clk);
            req = 1'b1; addr = a ^ 6'h2A;
            @(negedge clk);
            req = 1'b0;
        end
        while (done_cnt == n) @(negedge clk);
        repeat (12) @(negedge clk);
        chk(cs == 1'b0, "R9 no access after ignored request", 32'(cs), 0);
        chk(done_cnt == n + 1, "R9 single completion", done_cnt, n + 1);
        chk(dout == exp_word(a), "R10 word held after done", 32'(dout), 32'(exp_word(a)));
    endtask

    initial begin
        repeat (4) @(negedge clk);
        chk({cs, sk, mosi, done} == 4'b0, "R1 outputs in reset", 32'({cs, sk, mosi, done}), 0);
        chk(dout == '0, "R1 word in reset", 32'(dout), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk({cs, sk, mosi, done} == 4'b0, "R1 outputs after reset", 32'({cs, sk, mosi, done}), 0);
        for (int a = 0; a < (1 << ADDR_W); a++) begin
            read_word(ADDR_W'(a), (a % 4) == 1);
        end
        // back-to-back with request held high: guard time between accesses (R2)
        begin
            int n;
            n = done_cnt;
            @(negedge clk);
            req = 1'b1; addr = 6'd5; cur_addr = 6'd5;
            while (done_cnt < n + 1) @(negedge clk);
            chk(dout == exp_word(6'd5), "R10 first back-to-back word", 32'(dout), 32'(exp_word(6'd5)));
            while (done_cnt < n + 2) @(negedge clk);
            req = 1'b0;
            repeat (20) @(negedge clk);
            chk(done_cnt == n + 2, "R2 two back-to-back accesses", done_cnt, n + 2);
            chk(cs == 1'b0, "R9 idle after request dropped", 32'(cs), 0);
        end
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", done_cnt, (1 << ADDR_W) + 2);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule